// File: doc/BRIEF.md
# Serial Receive Break Guard

This block sits between a serial receive shifter and the receive FIFO. It watches the sampled receive line on each bit-sample strobe and counts consecutive low samples. If the line stays low for a whole frame time, the block declares a break. A frame time runs from the start bit through the first stop-bit position, which is `1 + DATA_W + PAR_EN + 1` samples. While the break lasts, every frame the shifter delivers is consumed and dropped, so nothing reaches the FIFO. Bit sampling carries on, so the sticky break flag sets again on every further low sample, even after software has cleared it.

The block keeps three status flags: framing error, parity error and break. Each flag sets from hardware events. Software clears a flag by the usual read-then-write-zero sequence, and only a flag that was read as 1 can be cleared. The raw receive pin level is also brought out, so software can tell a line held low apart from a single bad frame.

Frames flow from the shifter to the FIFO over valid/ready. Outside a break, the FIFO's ready passes straight back to the shifter, and a stalled FIFO holds a frame on the shifter side. During a break, or in the cycle a break is declared, the block raises `in_ready` itself and holds `out_valid` low, so the FIFO's back-pressure has no effect.

Top module: `rx_break_guard`

## Requirements
- R1: When the `FRAME_BITS`-th consecutive low sample is taken (`bit_stb`=1 with `rx_pin`=0), `brk_busy` rises on the next edge and the break flag (`sts_flags[2]`) reads 1 from that edge on.
- R2: A high sample resets the low run, so runs shorter than `FRAME_BITS` low samples never raise `brk_busy`. Cycles without `bit_stb` neither extend nor reset the run.
- R3: A frame taken with `in_valid`=1 and `in_ready`=1 whose stop sample `in_stop` is 0 sets the framing flag (`sts_flags[0]`) on the next edge. This holds whether the frame was forwarded or dropped.
- R4: A taken frame with `in_par_err`=1 sets the parity flag (`sts_flags[1]`) on the next edge.
- R5: While `brk_busy` is 1, and in the cycle a break is declared, `out_valid` is 0 and `in_ready` is 1, so frames are dropped.
- R6: Outside R5, `out_valid` equals `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready`.
- R7: While `brk_busy` is 1, every low sample sets the break flag again on the next edge, even when it was just cleared.
- R8: The break ends, with `brk_busy` falling on the next edge, only when `start_det` arrives after at least one high sample taken during the break. A `start_det` with no preceding high sample leaves the break in place.
- R9: A pulse on `sts_rd` arms every flag that reads 1 at that moment. A 1 on bit i of `sts_clr` clears flag i only if flag i is armed, and it also disarms flag i. On an unarmed flag it has no effect.
- R10: When a flag's set event and its armed clear fall in the same cycle, the flag stays 1.
- R11: `rx_level` always equals the current `rx_pin`.
- R12: During reset and right after it, all flags are 0 and `brk_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pin | input | 1 | Synchronised receive line level |
| bit_stb | input | 1 | Bit-sample strobe from the shifter |
| start_det | input | 1 | Start-bit detected pulse from the shifter |
| in_valid | input | 1 | Shifter has a complete frame |
| in_ready | output | 1 | Frame is taken (forwarded or dropped) |
| in_data | input | DATA_W | Received data byte |
| in_stop | input | 1 | Level of the stop sample of the frame |
| in_par_err | input | 1 | Parity check failed for the frame |
| out_valid | output | 1 | Frame offered to the FIFO |
| out_ready | input | 1 | FIFO can accept |
| out_data | output | DATA_W | Data to the FIFO |
| sts_rd | input | 1 | Status read strobe, arms flags that read 1 |
| sts_clr | input | 3 | Per-flag write-zero strobe: bit 0 framing, bit 1 parity, bit 2 break |
| sts_flags | output | 3 | Flags: bit 0 framing, bit 1 parity, bit 2 break |
| brk_busy | output | 1 | Break in progress |
| rx_level | output | 1 | Raw receive pin level |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is break declaration and frame delivery: the `FRAME_BITS`-th low sample lands together with `in_valid`. That frame must be dropped while its framing error is still recorded. The second pair is a flag set and an armed software clear, which meet in one cycle when a low sample arrives during a break just as software clears the break flag. Both are provoked by directed sequences and by long stretches of random stimulus with the line held low most of the time. A cycle-by-cycle reference model judges every output on every clock.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int FLAG_FER = 0;
  localparam int FLAG_PER = 1;
  localparam int FLAG_BRK = 2;
  localparam int NFLAGS   = 3;

  function automatic int frame_len(input int data_w, input int par_en);
    return 1 + data_w + par_en + 1;
  endfunction
endpackage

// File: rtl/brk_line_monitor.sv
module brk_line_monitor #(
  parameter int FRAME_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic rx_pin,
  input  logic start_det,
  output logic brk_busy,
  output logic brk_now,
  output logic brk_hit
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);

  logic [CW-1:0] low_cnt;
  logic          seen_high;
  logic          low_smp;
  logic          leave;

  always_comb begin
    low_smp = bit_stb && !rx_pin;
    brk_now = low_smp && !brk_busy && (low_cnt >= LAST);
    brk_hit = low_smp && (brk_busy || brk_now);
    leave   = brk_busy && start_det && seen_high;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      brk_busy  <= 1'b0;
      seen_high <= 1'b0;
    end else begin
      if (bit_stb) begin
        if (rx_pin)               low_cnt <= '0;
        else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
      end
      if (brk_now)    brk_busy <= 1'b1;
      else if (leave) brk_busy <= 1'b0;
      if (brk_busy && !leave) seen_high <= seen_high | (bit_stb && rx_pin);
      else                    seen_high <= 1'b0;
    end
  end
endmodule

// File: rtl/brk_status_flags.sv
module brk_status_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         rd,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] armed;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else begin
        flags[i] <= set[i] | (flags[i] & ~(clr[i] & armed[i]));
        if (rd) armed[i] <= flags[i];
        else    armed[i] <= armed[i] & ~clr[i];
      end
    end
  end
endmodule

// File: rtl/brk_fifo_gate.sv
module brk_fifo_gate #(
  parameter int DATA_W = 8
) (
  input  logic              block,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  always_comb begin
    out_valid = in_valid && !block;
    out_data  = in_data;
    in_ready  = block ? 1'b1 : out_ready;
  end
endmodule

// File: rtl/rx_break_guard.sv
module rx_break_guard
  import brk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAR_EN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pin,
  input  logic              bit_stb,
  input  logic              start_det,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_stop,
  input  logic              in_par_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              sts_rd,
  input  logic [2:0]        sts_clr,
  output logic [2:0]        sts_flags,
  output logic              brk_busy,
  output logic              rx_level
);
  localparam int FRAME_BITS = frame_len(DATA_W, PAR_EN);

  logic              brk_now;
  logic              brk_hit;
  logic              taken;
  logic [NFLAGS-1:0] flag_set;

  brk_line_monitor #(.FRAME_BITS(FRAME_BITS)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .rx_pin    (rx_pin),
    .start_det (start_det),
    .brk_busy  (brk_busy),
    .brk_now   (brk_now),
    .brk_hit   (brk_hit)
  );

  brk_fifo_gate #(.DATA_W(DATA_W)) u_gate (
    .block     (brk_busy || brk_now),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  always_comb begin
    taken              = in_valid && in_ready;
    flag_set           = '0;
    flag_set[FLAG_FER] = taken && !in_stop;
    flag_set[FLAG_PER] = taken && in_par_err;
    flag_set[FLAG_BRK] = brk_hit;
    rx_level           = rx_pin;
  end

  brk_status_flags #(.N(NFLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .rd    (sts_rd),
    .clr   (sts_clr),
    .flags (sts_flags)
  );
endmodule

// File: rtl/brk_guard_checks.sv
module brk_guard_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_pin,
  input logic              bit_stb,
  input logic              start_det,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_stop,
  input logic              in_par_err,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [2:0]        sts_flags,
  input logic              brk_busy
);
  p_gate_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_busy && in_valid |-> !out_valid && in_ready);

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid && (out_data == in_data) && (in_ready == out_ready));

  p_brk_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_busy) |-> sts_flags[2]);

  p_fer_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_stop |=> sts_flags[0]);

  p_per_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_par_err |=> sts_flags[1]);

  p_reassert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_busy && bit_stb && !rx_pin |=> sts_flags[2]);

  p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_busy) |-> $past(start_det));
endmodule

bind rx_break_guard brk_guard_checks #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_pin     (rx_pin),
  .bit_stb    (bit_stb),
  .start_det  (start_det),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_stop    (in_stop),
  .in_par_err (in_par_err),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .sts_flags  (sts_flags),
  .brk_busy   (brk_busy)
);

// File: tb/rx_break_guard_test.sv
`timescale 1ns/1ps
module rx_break_guard_test;
  localparam int DW = 8;
  localparam int FB = 1 + DW + 1 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_pin = 1'b1, bit_stb = 1'b0, start_det = 1'b0;
  logic in_valid = 1'b0, in_stop = 1'b1, in_par_err = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic sts_rd = 1'b0;
  logic [2:0] sts_clr = '0;
  logic in_ready, out_valid, brk_busy, rx_level;
  logic [DW-1:0] out_data;
  logic [2:0] sts_flags;

  always #2 clk = ~clk;

  rx_break_guard #(.DATA_W(DW), .PAR_EN(1)) uut (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .bit_stb(bit_stb),
    .start_det(start_det), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_stop(in_stop), .in_par_err(in_par_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sts_rd(sts_rd), .sts_clr(sts_clr), .sts_flags(sts_flags),
    .brk_busy(brk_busy), .rx_level(rx_level)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  string ctx = "R12";

  // reference model state
  int  m_low = 0;
  bit  m_busy = 0, m_seen = 0;
  bit [2:0] m_flg = 0, m_arm = 0;
  bit [31:0] rs = 32'h1234_5679;

  function automatic bit [31:0] rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  function automatic bit m_brk_now();
    return bit_stb && !rx_pin && !m_busy && (m_low + 1 >= FB);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) cycle-check: actual %0d expected %0d", req, ctx, act, exp);
    end
  endtask

  task automatic compare_all();
    bit gate;
    gate = m_busy || m_brk_now();
    chk(gate ? "R5" : "R6", int'(out_valid), int'(in_valid && !gate));
    chk(gate ? "R5" : "R6", int'(in_ready), gate ? 1 : int'(out_ready));
    chk("R6", int'(out_data), int'(in_data));
    chk("R3", int'(sts_flags[0]), int'(m_flg[0]));
    chk("R4", int'(sts_flags[1]), int'(m_flg[1]));
    chk("R1", int'(sts_flags[2]), int'(m_flg[2]));
    chk("R8", int'(brk_busy), int'(m_busy));
    chk("R11", int'(rx_level), int'(rx_pin));
  endtask

  task automatic model_step();
    bit now, gate, rdy, leave;
    bit [2:0] set;
    now   = m_brk_now();
    gate  = m_busy || now;
    rdy   = gate ? 1'b1 : out_ready;
    leave = m_busy && start_det && m_seen;
    set[0] = in_valid && rdy && !in_stop;
    set[1] = in_valid && rdy && in_par_err;
    set[2] = bit_stb && !rx_pin && gate;
    m_flg  = set | (m_flg & ~(sts_clr & m_arm));
    m_arm  = sts_rd ? m_flg_prev : (m_arm & ~sts_clr);
    m_seen = (m_busy && !leave) ? (m_seen | (bit_stb && rx_pin)) : 1'b0;
    if (now) m_busy = 1'b1; else if (leave) m_busy = 1'b0;
    if (bit_stb) m_low = rx_pin ? 0 : ((m_low < FB) ? m_low + 1 : FB);
  endtask

  bit [2:0] m_flg_prev;

  task automatic cyc(input bit stb, input bit rx, input bit st, input bit iv,
                     input bit [DW-1:0] d, input bit stop, input bit pe,
                     input bit ordy, input bit rd, input bit [2:0] clr);
    @(negedge clk);
    bit_stb = stb; rx_pin = rx; start_det = st; in_valid = iv; in_data = d;
    in_stop = stop; in_par_err = pe; out_ready = ordy; sts_rd = rd; sts_clr = clr;
    #1 compare_all();
    @(posedge clk);
    m_flg_prev = m_flg;
    model_step();
  endtask

  task automatic low_run(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
      cyc(0, 0, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    ctx = "R12";
    chk("R12", int'(sts_flags), 0);
    chk("R12", int'(brk_busy), 0);
    rst_n = 1'b1;

    ctx = "R6";  // pass-through with back-pressure
    cyc(0, 1, 0, 1, 8'hA5, 1, 0, 0, 0, 3'b000);
    cyc(0, 1, 0, 1, 8'hA5, 1, 0, 1, 0, 3'b000);
    ctx = "R4";
    cyc(0, 1, 0, 1, 8'h3C, 1, 1, 1, 0, 3'b000);
    ctx = "R9";  // clear without arming: no effect
    cyc(0, 1, 0, 0, 8'h00, 1, 0, 1, 0, 3'b111);
    cyc(0, 1, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    chk("R9", int'(sts_flags[1]), 1);
    cyc(0, 1, 0, 0, 8'h00, 1, 0, 1, 1, 3'b000);
    cyc(0, 1, 0, 0, 8'h00, 1, 0, 1, 0, 3'b010);
    cyc(0, 1, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    chk("R9", int'(sts_flags[1]), 0);

    ctx = "R2";  // short runs, broken by a high sample
    cyc(1, 1, 1, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    low_run(FB - 1);
    cyc(1, 1, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    low_run(FB - 1);
    chk("R2", int'(brk_busy), 0);
    cyc(1, 1, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);

    ctx = "R1";  // full low frame, frame delivered with the last sample
    low_run(FB - 1);
    cyc(1, 0, 0, 1, 8'h00, 0, 1, 0, 0, 3'b000);
    cyc(0, 0, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    chk("R1", int'(brk_busy), 1);
    chk("R3", int'(sts_flags[0]), 1);

    ctx = "R7";  // clear break while low, it sets again
    cyc(0, 0, 0, 0, 8'h00, 1, 0, 1, 1, 3'b000);
    cyc(0, 0, 0, 0, 8'h00, 1, 0, 1, 0, 3'b100);
    cyc(0, 0, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    chk("R7", int'(sts_flags[2]), 0);
    cyc(1, 0, 0, 1, 8'h11, 1, 0, 0, 0, 3'b000);
    cyc(0, 0, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    chk("R7", int'(sts_flags[2]), 1);

    ctx = "R10";  // set and armed clear together
    cyc(0, 0, 0, 0, 8'h00, 1, 0, 1, 1, 3'b000);
    cyc(1, 0, 0, 0, 8'h00, 1, 0, 1, 0, 3'b100);
    cyc(0, 0, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    chk("R10", int'(sts_flags[2]), 1);

    ctx = "R8";  // start without high keeps break, high then start ends it
    cyc(0, 0, 1, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    cyc(0, 0, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    chk("R8", int'(brk_busy), 1);
    cyc(1, 1, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    cyc(0, 1, 1, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    cyc(0, 1, 0, 0, 8'h00, 1, 0, 1, 0, 3'b000);
    chk("R8", int'(brk_busy), 0);

    ctx = "RANDOM-LOW";
    for (int k = 0; k < 8000; k++) begin
      bit [31:0] a, b;
      a = rnd(); b = rnd();
      cyc(a[2:0] < 3, (k < 4000) ? (a[7:4] > 13) : a[8], a[12:9] == 0, a[15:13] == 0,
          b[7:0], b[8] | b[9], b[10:0] == 11'h7, b[13:11] != 0,
          b[17:14] == 0, (b[20:18] == 0) ? b[23:21] : 3'b000);
      if (k == 4000) ctx = "RANDOM-MIX";
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule